// File: doc/BRIEF.md
# Carry-Increment Group Adder

This block is a purely combinational binary adder of parameterised width. It takes two operands and a carry input and produces the sum and a carry output. The word is split into groups of a parameterised size. The last group may be narrower when the width is not a multiple of the group size.

Bit-level generate (both operand bits set) and propagate (operand bits differ) are formed once for the whole word. Each group works out its internal carries on the assumption that no carry enters it. It keeps a running generate term and a running all-propagate term for every bit position. When the real carry into the group is known, each local carry is corrected by that carry gated with the running propagate term. The carry out of each group is the carry into the next group. A single XOR stage across the whole word then combines each propagate bit with the carry into that bit.

There is no data movement to pace and no state, so there is no handshake. The outputs follow the inputs within the same evaluation.

Top module: `cinc_adder`

## Requirements
- R1: For every operand pair and carry input, the concatenation {cout, sum} equals a + b + cin taken as an unsigned integer of WIDTH+1 bits.
- R2: Bit 0 of sum equals a[0] XOR b[0] XOR cin.
- R3: When a equals the bitwise inverse of b, every bit propagates. In that case cout equals cin, and sum is all ones when cin is 0 and all zeros when cin is 1.
- R4: When a[WIDTH-1] and b[WIDTH-1] are both 1, cout is 1 whatever the other inputs are.
- R5: When a[WIDTH-1] and b[WIDTH-1] are both 0, cout is 0 whatever the other inputs are.
- R6: R1 holds when WIDTH is not a whole multiple of GRP, in which case the highest group holds the remaining WIDTH mod GRP bits.
- R7: The block holds no state. sum and cout settle to the new result after any input change, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top bit |

## Verification
The bench builds two instances of the adder. The first has WIDTH 8 and GRP 3, which gives groups of 3, 3 and 2 bits. Its small input space lets every operand pair be tried with both carry values, and the narrow top group exercises the ragged case. The second has WIDTH 32 and GRP 5, with a 2-bit top group. It is driven with random operands and with the long carry chains of the all-propagate pattern, so a carry crosses six group boundaries. Both are compared against a plain integer sum.

// File: rtl/cinc_pkg.sv
package cinc_pkg;
  // number of groups needed to cover a word
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // width of group idx, the last one may be short
  function automatic int group_width(input int width, input int grp, input int idx);
    int rem;
    rem = width - idx * grp;
    return (rem < grp) ? rem : grp;
  endfunction
endpackage

// File: rtl/cinc_pg.sv
module cinc_pg #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] g,
  output logic [WIDTH-1:0] p
);
  // bit-level generate and propagate, shared by all groups
  assign g = a & b;
  assign p = a ^ b;
endmodule

// File: rtl/cinc_group.sv
module cinc_group #(
  parameter int GW = 4
) (
  input  logic [GW-1:0] g,
  input  logic [GW-1:0] p,
  input  logic          cin_grp,
  output logic [GW-1:0] carry,
  output logic          cout_grp
);
  logic [GW:0] lgen;   // local generate from group start up to bit i-1
  logic [GW:0] lprop;  // all-propagate from group start up to bit i-1

  // local prefix assuming no carry enters the group
  always_comb begin
    lgen[0]  = 1'b0;
    lprop[0] = 1'b1;
    for (int i = 0; i < GW; i++) begin
      lgen[i+1]  = g[i] | (p[i] & lgen[i]);
      lprop[i+1] = p[i] & lprop[i];
    end
  end

  // increment step: the late carry corrects the local carries
  always_comb begin
    for (int i = 0; i < GW; i++) begin
      carry[i] = lgen[i] | (lprop[i] & cin_grp);
    end
    cout_grp = lgen[GW] | (lprop[GW] & cin_grp);
  end

  always_comb begin : chk_group
    // a group that propagates on every bit hands its carry-in straight on
    if (&p) begin
      p_group_pass_r3: assert (cout_grp == cin_grp);
    end
    // the carry into the lowest bit of a group is the group carry-in
    p_group_entry_r6: assert (carry[0] == cin_grp);
  end
endmodule

// File: rtl/cinc_sum.sv
module cinc_sum #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] p,
  input  logic [WIDTH-1:0] c,
  output logic [WIDTH-1:0] sum
);
  // one XOR stage for the whole word
  assign sum = p ^ c;
endmodule

// File: rtl/cinc_adder.sv
module cinc_adder #(
  parameter int WIDTH = 32,
  parameter int GRP   = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NGRP = cinc_pkg::ceil_div(WIDTH, GRP);

  logic [WIDTH-1:0] g;
  logic [WIDTH-1:0] p;
  logic [WIDTH-1:0] c;
  logic [NGRP:0]    gcar;  // carry into each group, plus the final carry

  cinc_pg #(.WIDTH(WIDTH)) u_pg (
    .a (a),
    .b (b),
    .g (g),
    .p (p)
  );

  assign gcar[0] = cin;

  for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
    localparam int LO = gi * GRP;
    localparam int GW = cinc_pkg::group_width(WIDTH, GRP, gi);
    cinc_group #(.GW(GW)) u_group (
      .g        (g[LO +: GW]),
      .p        (p[LO +: GW]),
      .cin_grp  (gcar[gi]),
      .carry    (c[LO +: GW]),
      .cout_grp (gcar[gi+1])
    );
  end

  cinc_sum #(.WIDTH(WIDTH)) u_sum (
    .p   (p),
    .c   (c),
    .sum (sum)
  );

  assign cout = gcar[NGRP];

  always_comb begin : chk_top
    p_sum_match_r1: assert ({cout, sum} ==
      ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}));
    p_low_bit_r2: assert (sum[0] == (a[0] ^ b[0] ^ cin));
    if (a[WIDTH-1] && b[WIDTH-1]) begin
      p_top_generate_r4: assert (cout == 1'b1);
    end
    if (!a[WIDTH-1] && !b[WIDTH-1]) begin
      p_top_kill_r5: assert (cout == 1'b0);
    end
    if (a == ~b) begin
      p_full_propagate_r3: assert (cout == cin);
    end
  end
endmodule

// File: tb/test_cinc_adder.sv
module test_cinc_adder;
  localparam int CLK_PERIOD = 10;
  localparam int W8  = 8;
  localparam int W32 = 32;
  localparam int RAND_RUNS = 3000;
  localparam int WATCHDOG  = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W8-1:0]  a8, b8, s8;
  logic           ci8, co8;
  logic [W32-1:0] a32, b32, s32;
  logic           ci32, co32;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  cinc_adder #(.WIDTH(W8), .GRP(3)) i_cinc_adder_n8 (
    .a(a8), .b(b8), .cin(ci8), .sum(s8), .cout(co8)
  );

  cinc_adder #(.WIDTH(W32), .GRP(5)) i_cinc_adder (
    .a(a32), .b(b32), .cin(ci32), .sum(s32), .cout(co32)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // compare the 8-bit instance against an integer reference
  task automatic cmp8();
    longint ref_v;
    ref_v = longint'(a8) + longint'(b8) + longint'(ci8);
    chk("R1/R6 n8", longint'({co8, s8}), ref_v);
    chk("R2 n8", longint'(s8[0]), longint'(a8[0] ^ b8[0] ^ ci8));
    if (a8[W8-1] && b8[W8-1]) chk("R4 n8", longint'(co8), 1);
    if (!a8[W8-1] && !b8[W8-1]) chk("R5 n8", longint'(co8), 0);
  endtask

  task automatic cmp32();
    longint ref_v;
    ref_v = longint'(a32) + longint'(b32) + longint'(ci32);
    chk("R1/R6 w32", longint'({co32, s32}), ref_v);
    if (a32[W32-1] && b32[W32-1]) chk("R4 w32", longint'(co32), 1);
    if (!a32[W32-1] && !b32[W32-1]) chk("R5 w32", longint'(co32), 0);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!done && cycles >= WATCHDOG) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    a8 = '0; b8 = '0; ci8 = 1'b0;
    a32 = '0; b32 = '0; ci32 = 1'b0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // idle state: all-zero inputs give all-zero outputs
    chk("R1 idle n8", longint'({co8, s8}), 0);
    chk("R1 idle w32", longint'({co32, s32}), 0);

    // R7: no clock between input change and result
    a32 = 32'h0000_00ff; b32 = 32'h0000_0001; ci32 = 1'b0;
    #1 chk("R7 settle", longint'({co32, s32}), 64'h100);
    a32 = 32'hffff_ffff; b32 = 32'h0; ci32 = 1'b1;
    #1 chk("R7 settle2", longint'({co32, s32}), 64'h1_0000_0000);

    // R3: full propagate on both instances and both carries
    for (int k = 0; k < 2; k++) begin
      @(posedge clk); #1;
      a8 = 8'h5a; b8 = ~a8; ci8 = k[0];
      a32 = 32'hc3a5_0f1e; b32 = ~a32; ci32 = k[0];
      @(negedge clk);
      chk("R3 cout n8", longint'(co8), longint'(k));
      chk("R3 sum n8", longint'(s8), (k == 0) ? 64'hff : 64'h0);
      chk("R3 cout w32", longint'(co32), longint'(k));
      chk("R3 sum w32", longint'(s32), (k == 0) ? 64'hffff_ffff : 64'h0);
    end

    // R1/R6 exhaustive on the 8-bit instance, one vector per clock
    for (int v = 0; v < (1 << (2*W8+1)); v++) begin
      @(posedge clk); #1;
      a8 = v[W8-1:0]; b8 = v[2*W8-1:W8]; ci8 = v[2*W8];
      @(negedge clk);
      cmp8();
    end

    // R1/R4/R5/R6 random on the 32-bit instance
    for (int r = 0; r < RAND_RUNS; r++) begin
      @(posedge clk); #1;
      a32 = $urandom; b32 = $urandom; ci32 = $urandom_range(0, 1);
      if (r % 4 == 1) b32 = ~a32 ^ (32'h1 << $urandom_range(0, 31));
      @(negedge clk);
      cmp32();
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule